// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches an N-bit word carried on two wires per bit, a true rail and a false rail, and tells a clocked consumer when the whole word is present and when the whole word has been withdrawn. Each bit is classified by its two rails. A bit is valid when exactly one rail is high. Every valid flag enters a balanced tree of two-input Muller C-element nodes. Each node is held in a register, so the tree gives one register stage per level. The root, `done_o`, has hysteresis. It rises only once every bit has been valid and falls only once every bit has gone back to the spacer. It holds its value through any mixed state in between.

Besides the completion flag, the block turns the word into single-rail data (the true rails) and flags every bit whose two rails are both high. These outputs pass through a delay line as deep as the tree, so `data_o`, `err_o` and `any_err_o` always describe the same input sample that the completion flag is acting on. A producer that follows a four-phase protocol raises its bits in any order and waits for `done_o`. It then drops its bits in any order and waits for `done_o` to clear.

Top module: `dr_completion_detect`

## Requirements
- R1: Bit i is coded by the pair {rail_t_i[i], rail_f_i[i]}: 2'b00 is the spacer (no data), 2'b01 is logic 0, 2'b10 is logic 1 and 2'b11 is illegal. A bit counts as valid only for 2'b01 or 2'b10.
- R2: An illegal bit sets its `err_o` bit, never counts as valid (so `done_o` cannot rise while it persists), and counts like a spacer when the word returns to empty.
- R3: With the default N = 8, the tree has LVL = ceil(log2 N) = 3 levels. When bits become valid one by one and are held, `done_o` goes from 0 to 1 on the LVL-th rising clock edge, counting the first edge that samples every bit valid.
- R4: While the word holds a mix of valid and non-valid bits, `done_o` keeps its previous value.
- R5: When bits return to the spacer one by one and are held, `done_o` goes from 1 to 0 on the LVL-th rising edge, counting the first edge that samples every bit non-valid.
- R6: `data_o` equals `rail_t_i` and `err_o` equals `rail_t_i & rail_f_i` as sampled LVL edges earlier. Both are meaningful whatever the state of `done_o`.
- R7: `any_err_o` is 1 exactly when some bit of `err_o` is 1, with the same alignment.
- R8: A low `rst_n` at a rising edge clears `done_o`, `data_o`, `err_o`, `any_err_o` and every tree node to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rail_t_i | input | N | True rail of each bit |
| rail_f_i | input | N | False rail of each bit |
| data_o | output | N | Decoded single-rail word, LVL edges late |
| err_o | output | N | Per-bit illegal-code flag, LVL edges late |
| any_err_o | output | 1 | OR of all illegal-code flags, LVL edges late |
| done_o | output | 1 | Completion flag with C-element hysteresis |

## Verification
A tree node stuck at the wrong value shows up at `done_o` as a rise or fall that comes early, late or never. In a four-phase exchange, that mistake appears within LVL edges of the last bit changing. A node that forgets its hysteresis makes `done_o` drop or rise while the word is still mixed. The bench catches this on the very next sample, because it checks `done_o` on every cycle of each staged exchange. A wrong delay depth or a misrouted rail shows in `data_o` or `err_o` on the first mismatching sample. Random input traffic keeps those outputs compared on every cycle.

// File: rtl/dr_cd_pkg.sv
// Package: shared code values and helpers for the dual-rail completion detector.
// Assumes the pair of rails of one bit is packed as {true, false}.
package dr_cd_pkg;

    typedef enum logic [1:0] {
        DR_SPACER  = 2'b00,
        DR_ZERO    = 2'b01,
        DR_ONE     = 2'b10,
        DR_ILLEGAL = 2'b11
    } dr_code_e;

    // Classify one bit from its two rails.
    function automatic dr_code_e dr_classify(input logic t, input logic f);
        return dr_code_e'({t, f});
    endfunction

    // A bit carries data only for one of the two legal data codes.
    function automatic logic dr_is_valid(input dr_code_e c);
        return (c == DR_ZERO) || (c == DR_ONE);
    endfunction

endpackage

// File: rtl/dr_rail_decode.sv
// Module: dr_rail_decode
// Splits each dual-rail bit into a valid flag, an illegal flag and a data bit.
// Purely combinational; assumes nothing about the order in which rails change.
module dr_rail_decode
    import dr_cd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] rail_t,
    input  logic [N-1:0] rail_f,
    output logic [N-1:0] valid,
    output logic [N-1:0] bad,
    output logic [N-1:0] data
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        dr_code_e code;

        // Classify the bit and derive its flags.
        always_comb begin
            code     = dr_classify(rail_t[i], rail_f[i]);
            valid[i] = dr_is_valid(code);
            bad[i]   = (code == DR_ILLEGAL);
            data[i]  = rail_t[i];
        end

        // Check that an illegal bit is never reported as valid (R2).
        always_comb begin
            a_r2_bad_not_valid: assert (!(valid[i] && bad[i]));
        end
    end

endmodule

// File: rtl/dr_celem.sv
// Module: dr_celem
// One registered two-input Muller C-element. Assumes the synchronous reset
// brings the node to 0, which is the value it holds while the word is empty.
module dr_celem (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic q
);

    // Follow the inputs when they agree; otherwise hold the stored value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (a && b)
            q <= 1'b1;
        else if (!a && !b)
            q <= 1'b0;
    end

    // R4: disagreeing inputs leave the node unchanged.
    a_r4_hold_on_disagree: assert property (@(posedge clk) disable iff (!rst_n)
        (a != b) |=> $stable(q));

    // R3: the node only rises after both inputs were high.
    a_r3_rise_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(q)) |-> $past(a && b));

    // R5: the node only falls after both inputs were low.
    a_r5_fall_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(q)) |-> $past(!a && !b));

endmodule

// File: rtl/dr_celem_tree.sv
// Module: dr_celem_tree
// Balanced tree of registered C-elements in heap order: node 0 is the root,
// node k has children 2k+1 and 2k+2, and the leaves hold the padded inputs.
// Assumes N >= 2. Leaves above N-1 repeat the last input. A node fed the same
// signal twice acts as a plain register, so the padding never blocks
// completion and every path keeps the same depth.
module dr_celem_tree #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] leaf,
    output logic         root
);

    localparam int LVL   = $clog2(N);
    localparam int W     = 1 << LVL;
    localparam int NODES = 2 * W - 1;

    wire [NODES-1:0] nd;

    // Leaves: real inputs, then copies of the last input as padding.
    for (genvar k = 0; k < W; k++) begin : g_leaf
        if (k < N) begin : g_real
            assign nd[W-1+k] = leaf[k];
        end else begin : g_pad
            assign nd[W-1+k] = leaf[N-1];
        end
    end

    // Inner nodes: one registered C-element each.
    for (genvar k = 0; k < W - 1; k++) begin : g_node
        dr_celem u_cel (
            .clk   (clk),
            .rst_n (rst_n),
            .a     (nd[2*k+1]),
            .b     (nd[2*k+2]),
            .q     (nd[k])
        );
    end

    assign root = nd[0];

endmodule

// File: rtl/dr_align_pipe.sv
// Module: dr_align_pipe
// Fixed-depth delay line that keeps side outputs in step with the C-element
// tree. Assumes DEPTH >= 1; the reset clears every stage.
module dr_align_pipe #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [DEPTH-1:0][WIDTH-1:0] stage;

    // Shift the sample one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < DEPTH; s++)
                stage[s] <= stage[s-1];
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/dr_completion_detect.sv
// Module: dr_completion_detect (top)
// Dual-rail completion detector. It decodes the rails, feeds the per-bit valid
// flags to a registered C-element tree, and delays data and error flags by the
// tree depth. Assumes N >= 2 and rails that are already synchronous to clk.
module dr_completion_detect #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rail_t_i,
    input  logic [N-1:0] rail_f_i,
    output logic [N-1:0] data_o,
    output logic [N-1:0] err_o,
    output logic         any_err_o,
    output logic         done_o
);

    localparam int LVL  = $clog2(N);
    localparam int PW   = 2 * N + 1;

    logic [N-1:0] bit_valid;
    logic [N-1:0] bit_bad;
    logic [N-1:0] bit_data;
    logic [PW-1:0] pipe_in;
    logic [PW-1:0] pipe_out;

    dr_rail_decode #(.N(N)) u_dec (
        .rail_t (rail_t_i),
        .rail_f (rail_f_i),
        .valid  (bit_valid),
        .bad    (bit_bad),
        .data   (bit_data)
    );

    dr_celem_tree #(.N(N)) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .leaf  (bit_valid),
        .root  (done_o)
    );

    // Bundle the side outputs so they share one delay line.
    assign pipe_in = {(|bit_bad), bit_bad, bit_data};

    dr_align_pipe #(.WIDTH(PW), .DEPTH(LVL)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pipe_in),
        .q     (pipe_out)
    );

    assign any_err_o = pipe_out[PW-1];
    assign err_o     = pipe_out[2*N-1:N];
    assign data_o    = pipe_out[N-1:0];

    // R7: the summary flag agrees with the delayed per-bit flags.
    a_r7_any_err_matches: assert property (@(posedge clk) disable iff (!rst_n)
        any_err_o == (|err_o));

endmodule

// File: tb/dr_completion_detect_tb.sv
// Bench for dr_completion_detect: staged four-phase exchanges with random
// bit order, directed illegal-code and reset cases, then random traffic.
module dr_completion_detect_tb;

    localparam int NB         = 8;
    localparam int LVL        = $clog2(NB);
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] rt = '0;
    logic [NB-1:0] rf = '0;
    logic [NB-1:0] data_o;
    logic [NB-1:0] err_o;
    logic          any_err_o;
    logic          done_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit chk_done = 1'b1;

    // Expected-value history, newest sample at index 0.
    logic [NB-1:0] h_data [0:LVL-1];
    logic [NB-1:0] h_err  [0:LVL-1];
    logic          h_av   [0:LVL-1];
    logic          h_as   [0:LVL-1];
    logic          exp_done = 1'b0;
    logic          prev_exp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dr_completion_detect #(.N(NB)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_t_i  (rt),
        .rail_f_i  (rf),
        .data_o    (data_o),
        .err_o     (err_o),
        .any_err_o (any_err_o),
        .done_o    (done_o)
    );

    function automatic logic all_valid(input logic [NB-1:0] t, input logic [NB-1:0] f);
        return &(t ^ f);
    endfunction

    function automatic logic all_empty(input logic [NB-1:0] t, input logic [NB-1:0] f);
        return ~|(t ^ f);
    endfunction

    // Reference model updated at every rising edge.
    always @(posedge clk) begin
        prev_exp = exp_done;
        if (!rst_n) begin
            for (int i = 0; i < LVL; i++) begin
                h_data[i] = '0; h_err[i] = '0; h_av[i] = 1'b0; h_as[i] = 1'b0;
            end
            exp_done = 1'b0;
        end else begin
            for (int i = LVL - 1; i > 0; i--) begin
                h_data[i] = h_data[i-1]; h_err[i] = h_err[i-1];
                h_av[i] = h_av[i-1];     h_as[i] = h_as[i-1];
            end
            h_data[0] = rt;
            h_err[0]  = rt & rf;
            h_av[0]   = all_valid(rt, rf);
            h_as[0]   = all_empty(rt, rf);
            if (h_av[LVL-1])      exp_done = 1'b1;
            else if (h_as[LVL-1]) exp_done = 1'b0;
        end
    end

    task automatic check1(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model away from the clock edge.
    task automatic cyc();
        @(negedge clk);
        check1("R6 data", 32'(data_o), 32'(h_data[LVL-1]));
        check1("R6 err", 32'(err_o), 32'(h_err[LVL-1]));
        check1("R7 any_err", 32'(any_err_o), 32'(|h_err[LVL-1]));
        if (chk_done) begin
            if (exp_done && !prev_exp)      check1("R3 done rise", 32'(done_o), 32'(exp_done));
            else if (!exp_done && prev_exp) check1("R5 done fall", 32'(done_o), 32'(exp_done));
            else                            check1("R4 done hold", 32'(done_o), 32'(exp_done));
        end
    endtask

    task automatic drive(input logic [NB-1:0] w, input logic [NB-1:0] m);
        rt = w & m;
        rf = ~w & m;
    endtask

    // One four-phase exchange with bits arriving and leaving in random order.
    task automatic exchange();
        logic [NB-1:0] w;
        logic [NB-1:0] m;
        w = NB'($urandom);
        m = '0;
        while (m != '1) begin
            m = m | NB'($urandom & $urandom);
            drive(w, m);
            cyc();
        end
        for (int i = 0; i < 3 * LVL && !done_o; i++) cyc();
        check1("R3 done reached", 32'(done_o), 32'd1);
        while (m != '0) begin
            m = m & ~NB'($urandom & $urandom);
            drive(w, m);
            cyc();
        end
        for (int i = 0; i < 3 * LVL && done_o; i++) cyc();
        check1("R5 done cleared", 32'(done_o), 32'd0);
    endtask

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));

        // R8: reset with garbage on the rails.
        rt = NB'($urandom); rf = NB'($urandom);
        repeat (3) @(negedge clk);
        check1("R8 reset done", 32'(done_o), 32'd0);
        check1("R8 reset data", 32'(data_o), 32'd0);
        check1("R8 reset err", 32'(err_o), 32'd0);
        check1("R8 reset any_err", 32'(any_err_o), 32'd0);
        rt = '0; rf = '0;
        rst_n = 1'b1;
        cyc();

        // R1: all-zero and all-one words complete.
        drive('0, '1); repeat (LVL + 1) cyc();
        check1("R1 zero word valid", 32'(done_o), 32'd1);
        drive('0, '0); repeat (LVL + 1) cyc();
        drive('1, '1); repeat (LVL + 1) cyc();
        check1("R1 one word valid", 32'(done_o), 32'd1);
        drive('1, '0); repeat (LVL + 1) cyc();

        // R3, R4, R5: staged exchanges in random order.
        for (int r = 0; r < 60; r++) exchange();

        // R2: one illegal bit blocks completion.
        drive(8'hA5, '1);
        rt[3] = 1'b1; rf[3] = 1'b1;
        repeat (LVL + 3) cyc();
        check1("R2 illegal blocks done", 32'(done_o), 32'd0);
        check1("R2 illegal flagged", 32'(err_o), 32'h08);
        drive(8'hA5, '1); repeat (LVL + 1) cyc();
        check1("R2 done after repair", 32'(done_o), 32'd1);
        // R2: an illegal bit counts as empty for the return phase.
        rt = '0; rf = '0; rt[5] = 1'b1; rf[5] = 1'b1;
        repeat (LVL + 1) cyc();
        check1("R2 illegal counts empty", 32'(done_o), 32'd0);
        rt = '0; rf = '0; repeat (LVL + 1) cyc();

        // R8: reset while done is high.
        drive(8'h3C, '1); repeat (LVL + 1) cyc();
        check1("R8 pre-reset done", 32'(done_o), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check1("R8 mid reset done", 32'(done_o), 32'd0);
        check1("R8 mid reset data", 32'(data_o), 32'd0);
        drive('0, '0);
        rst_n = 1'b1;
        cyc();

        // R6, R7: random traffic including illegal codes; done not modelled here.
        chk_done = 1'b0;
        for (int i = 0; i < 400; i++) begin
            rt = NB'($urandom); rf = NB'($urandom);
            cyc();
        end
        rt = '0; rf = '0;
        repeat (LVL + 1) cyc();
        chk_done = 1'b1;
        check1("R5 empty after traffic", 32'(done_o), 32'd0);
        for (int r = 0; r < 10; r++) exchange();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule